// File: doc/BRIEF.md
# TDC calibration pulse sequencer

This block produces start/stop strobe pairs for calibrating time-to-digital converters. One start strobe goes to every converter channel as a common start. A stop strobe, also shared by all channels, follows after a delay that changes from sample to sample. Sweeping the delay across a range lets software map the converter's non-linearity.

A host writes four settings through a small write-only register port:

- which reference clock rate times the delay;
- how many samples make up one run;
- the gap between samples;
- the largest delay allowed.

A one-cycle go strobe launches a run. The six reference rates are modelled as fractional clock enables derived from a 160 MHz system clock. A phase accumulator restarts at every start strobe, so the delay of k reference periods comes out as ceil(k*160/f) system cycles.

Top module: `tdc_cal_seq`

## Requirements
- R1: While reset is asserted, start_pulse, stop_pulse, busy and done are all low.
- R2: A go strobe sampled while idle with a non-zero sample count raises start_pulse in the cycle after it. busy rises in that same cycle.
- R3: The clock select code maps 0, 1, 2, 3, 4 and 5 to 40, 32, 25, 20, 16 and 10 MHz. Codes 6 and 7 act as 40 MHz. A stop for a delay of k periods at rate f comes exactly ceil(k*160/f) cycles after its start.
- R4: The first sample of a run uses k = 1, and each later sample uses k+1. When k+1 would exceed the latched maximum, the next sample uses k = 1 again. A maximum of 0 acts as 1.
- R5: After each stop that is not the last, the next start comes gap+1 cycles later.
- R6: A run with sample count N emits exactly N start strobes and N stop strobes, each one cycle wide.
- R7: busy stays high from the first start through the cycle of the last stop. done pulses for one cycle right after that last stop, with busy already low.
- R8: A go strobe with sample count 0 pulses done in the next cycle. It emits no start or stop, and busy stays low.
- R9: A go strobe sampled while busy is high has no effect on the run in progress.
- R10: The settings are captured at the accepted go strobe. Register writes made during a run do not change that run.
- R11: Register addresses are: 0 = clock select (bits 2:0), 1 = sample count, 2 = gap in cycles, 3 = maximum delay in reference periods. A write takes effect at the clock edge where cfg_we is high.
- R12: start_pulse and stop_pulse are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 160 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 16 | Register write data |
| go | input | 1 | One-cycle run request |
| start_pulse | output | 1 | Common start strobe |
| stop_pulse | output | 1 | Fanned-out stop strobe |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run strobe |

## Verification
All results are due at fixed offsets from the accepted go strobe:

- start and busy: one cycle after go;
- each stop: ceil(k*160/f) cycles after its start;
- the next start: gap+1 cycles after a stop;
- done: one cycle after the last stop, or one cycle after go when the count is zero.

At each accepted go, the bench's model writes these cycle numbers into per-cycle expectation tables. It then compares every output against the tables once per clock, at the falling edge. The stimulus covers every select code, wrap of the delay, a zero maximum, a zero count, go strobes during a run and at the done cycle, and register writes during a run.

// File: rtl/tdc_cal_seq.sv
module tdc_cal_seq #(
  parameter int CW      = 16,
  parameter int SYS_MHZ = 160
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [CW-1:0] cfg_wdata,
  input  logic          go,
  output logic          start_pulse,
  output logic          stop_pulse,
  output logic          busy,
  output logic          done
);
  localparam int AW = $clog2(2 * SYS_MHZ);
  localparam logic [AW-1:0] SYS = AW'(SYS_MHZ);

  typedef enum logic [1:0] {IDLE, WAIT, GAP, FIN} st_t;
  st_t st;

  logic [2:0]    r_sel;
  logic [CW-1:0] r_cnt, r_gap, r_max;
  logic [AW-1:0] rate_l, acc;
  logic [CW-1:0] gap_l, max_l, left, ticks, k, gcnt;
  logic [AW-1:0] rate_sel;
  logic [AW-1:0] acc_sum;

  always_comb begin
    case (r_sel)
      3'd1:    rate_sel = AW'(32);
      3'd2:    rate_sel = AW'(25);
      3'd3:    rate_sel = AW'(20);
      3'd4:    rate_sel = AW'(16);
      3'd5:    rate_sel = AW'(10);
      default: rate_sel = AW'(40);
    endcase
  end

  assign acc_sum = acc + rate_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_sel <= '0; r_cnt <= '0; r_gap <= '0; r_max <= '0;
      rate_l <= '0; acc <= '0; gap_l <= '0; max_l <= CW'(1);
      left <= '0; ticks <= '0; k <= CW'(1); gcnt <= '0;
      st <= IDLE;
      start_pulse <= 1'b0; stop_pulse <= 1'b0; busy <= 1'b0; done <= 1'b0;
    end else begin
      start_pulse <= 1'b0;
      stop_pulse  <= 1'b0;
      done        <= 1'b0;
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: r_sel <= cfg_wdata[2:0];
          2'd1: r_cnt <= cfg_wdata;
          2'd2: r_gap <= cfg_wdata;
          default: r_max <= cfg_wdata;
        endcase
      end
      case (st)
        IDLE: if (go) begin
          rate_l <= rate_sel;
          gap_l  <= r_gap;
          max_l  <= (r_max == '0) ? CW'(1) : r_max;
          if (r_cnt == '0) begin
            done <= 1'b1;
          end else begin
            left        <= r_cnt;
            k           <= CW'(1);
            ticks       <= '0;
            acc         <= '0;
            start_pulse <= 1'b1;
            busy        <= 1'b1;
            st          <= WAIT;
          end
        end
        WAIT: begin
          if (acc_sum >= SYS) begin
            acc <= acc_sum - SYS;
            if (ticks + CW'(1) == k) begin
              stop_pulse <= 1'b1;
              ticks      <= '0;
              k          <= (k >= max_l) ? CW'(1) : k + CW'(1);
              left       <= left - CW'(1);
              if (left == CW'(1)) st <= FIN;
              else begin
                gcnt <= gap_l;
                st   <= GAP;
              end
            end else begin
              ticks <= ticks + CW'(1);
            end
          end else begin
            acc <= acc_sum;
          end
        end
        GAP: begin
          if (gcnt == '0) begin
            start_pulse <= 1'b1;
            acc         <= '0;
            st          <= WAIT;
          end else begin
            gcnt <= gcnt - CW'(1);
          end
        end
        default: begin
          busy <= 1'b0;
          done <= 1'b1;
          st   <= IDLE;
        end
      endcase
    end
  end

  assert_start_in_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> busy);
  assert_rise_with_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> start_pulse);
  assert_stop_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |-> busy);
  assert_done_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_fall_gives_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_stop_one_wide_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> !stop_pulse);
  assert_start_one_wide_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
  assert_no_overlap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_pulse && stop_pulse));
  assert_delay_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (k >= CW'(1) && k <= max_l));
  assert_go_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go) |=> (busy || done));
endmodule

// File: tb/test_tdc_cal_seq.sv
module test_tdc_cal_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic go = 1'b0;
  logic start_pulse, stop_pulse, busy, done;

  always #2.5 clk = ~clk;

  tdc_cal_seq i_tdc_cal_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .go(go), .start_pulse(start_pulse),
    .stop_pulse(stop_pulse), .busy(busy), .done(done));

  int compared = 0, mismatched = 0;
  int cyc = 0, busy_end = -1, blo = 1, bhi = 0;
  int sh_sel = 0, sh_cnt = 0, sh_gap = 0, sh_max = 0;
  bit exp_start[int], exp_stop[int], exp_done[int];
  bit finished = 0;

  function automatic int rate_of(int s);
    case (s)
      1: return 32; 2: return 25; 3: return 20; 4: return 16; 5: return 10;
      default: return 40;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // Behavioural model: on each accepted go, the cycle numbers of all events are scheduled
  always @(posedge clk) if (rst_n) begin
    cyc++;
    if (go && cyc > busy_end) begin
      int f, mx, k, t, n;
      f = rate_of(sh_sel);
      mx = (sh_max == 0) ? 1 : sh_max;
      if (sh_cnt == 0) begin
        exp_done[cyc] = 1;
        busy_end = cyc;
      end else begin
        k = 1; t = cyc;
        for (int i = 0; i < sh_cnt; i++) begin
          exp_start[t] = 1;
          n = (k * 160 + f - 1) / f;
          exp_stop[t + n] = 1;
          k = (k + 1 > mx) ? 1 : k + 1;
          if (i == sh_cnt - 1) begin
            blo = cyc; bhi = t + n;
            exp_done[t + n + 1] = 1;
            busy_end = t + n + 1;
          end
          t = t + n + sh_gap + 1;
        end
      end
    end
    if (cfg_we) begin
      case (cfg_addr)
        2'd0: sh_sel = int'(cfg_wdata[2:0]);
        2'd1: sh_cnt = int'(cfg_wdata);
        2'd2: sh_gap = int'(cfg_wdata);
        default: sh_max = int'(cfg_wdata);
      endcase
    end
  end

  always @(negedge clk) if (rst_n && cyc > 0) begin
    chk("R2/R5 start", int'(start_pulse), int'(exp_start.exists(cyc)));
    chk("R3/R4 stop", int'(stop_pulse), int'(exp_stop.exists(cyc)));
    chk("R7 busy", int'(busy), int'(cyc >= blo && cyc <= bhi));
    chk("R7/R8 done", int'(done), int'(exp_done.exists(cyc)));
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog expired actual 0 expected 1");
    summary();
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_go();
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
  endtask

  task automatic setup(int s, int n, int g, int m);
    wr(0, s); wr(1, n); wr(2, g); wr(3, m);
  endtask

  task automatic wait_idle();
    while (cyc <= busy_end + 1) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    // R1: outputs held low during reset
    repeat (3) @(negedge clk);
    chk("R1 reset start", int'(start_pulse), 0);
    chk("R1 reset stop", int'(stop_pulse), 0);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R11, R4 wrap with maximum 3 at 40 MHz
    setup(0, 7, 2, 3); pulse_go(); wait_idle();
    // R3 fractional 25 MHz ticks, zero gap (R5)
    setup(2, 5, 0, 10); pulse_go(); wait_idle();
    // R4 maximum 0 acts as 1, 10 MHz
    setup(5, 3, 5, 0); pulse_go(); wait_idle();
    // R3 remaining codes, including 6 and 7 as 40 MHz
    for (int s = 1; s < 8; s++) begin
      setup(s, 3, 1, 4); pulse_go(); wait_idle();
    end
    // R8 zero count
    setup(0, 0, 0, 2); pulse_go(); wait_idle();
    // R8 then immediate go accepted after done
    pulse_go(); wr(1, 2); pulse_go(); wait_idle();
    // R9 go during run; R10 writes during run have no effect
    setup(3, 4, 3, 5); pulse_go();
    repeat (4) @(negedge clk);
    pulse_go();
    wr(0, 5); wr(1, 9); wr(3, 1);
    pulse_go();
    wait_idle();
    // R9 go held across the done cycle: first acceptance after idle starts a new run
    setup(0, 1, 0, 1);
    @(negedge clk); go = 1'b1;
    repeat (12) @(negedge clk); go = 1'b0;
    wait_idle();
    // R6 longer run, wraps several times (R4)
    setup(4, 12, 2, 4); pulse_go(); wait_idle();
    summary();
  end
endmodule